// File: doc/BRIEF.md
# Sleep and Interrupt Wake-up Controller

This block sequences power-down for a small microcontroller core. The instruction decoder raises a one-cycle strobe when a sleep instruction executes. The controller then decides between two outcomes. If an enabled interrupt source is already flagged, the instruction collapses into a no-operation. Otherwise the controller gates core clocking off, clears the watchdog and records the power-down in two active-low status bits.

While asleep, any source whose individual enable and flag bits are both set wakes the core. The global interrupt enable plays no part in that decision. For crystal-type oscillator modes the controller first counts an oscillator start-up delay; for external-clock and RC modes it releases at once. On release, a set global enable inserts one dummy cycle and then strobes a load of the interrupt vector address into the program counter. A clear global enable lets execution continue in line with the next instruction.

A separate watchdog-clear strobe from the decoder also pulses the watchdog clear output and sets both status bits. Software tells an executed sleep from a no-operation by reading the power-down bit afterwards.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, pwrdn_n and tmo_n are 1, core_clk_en is 1, and wdt_clr and vec_load are 0.
- R2: The wake condition is true when any bit i has irq_en[i] and irq_flag[i] both 1, whatever gie is. A flag whose enable is 0 never wakes the core.
- R3: A sleep_req sampled in the same cycle as a true wake condition is a no-operation. The core keeps running, wdt_clr stays 0, and pwrdn_n and tmo_n keep their values.
- R4: A sleep_req sampled with the wake condition false enters sleep. On the next cycle core_clk_en is 0, pwrdn_n is 0 and tmo_n is 1, and wdt_clr is 1 for exactly one cycle.
- R5: While asleep, a wake condition in any cycle, including the first cycle after entry, starts the release. Once started, the release completes even if the wake condition drops.
- R6: For osc_mode 2'b00, 2'b01 and 2'b10 (crystal types), core_clk_en returns to 1 after exactly 1024 clock edges, counted from the edge that first samples the wake condition. For osc_mode 2'b11 (external clock or RC), core_clk_en returns to 1 after that edge.
- R7: If gie is 1 when the release completes, the first cycle with core_clk_en at 1 is a dummy cycle with vec_load 0. The next cycle has vec_load 1 for one cycle with vec_addr 13'h0004.
- R8: If gie is 0 when the release completes, vec_load stays 0. vec_addr is 0 whenever vec_load is 0.
- R9: A clrwdt_req while running gives a one-cycle wdt_clr on the next cycle and sets both pwrdn_n and tmo_n to 1.
- R10: While core_clk_en is 0, sleep_req and clrwdt_req have no effect: there is no wdt_clr pulse, and pwrdn_n stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep instruction strobe from the decoder |
| clrwdt_req | input | 1 | Watchdog-clear instruction strobe |
| irq_en | input | NUM_SRC | Per-source interrupt enables |
| irq_flag | input | NUM_SRC | Per-source interrupt flags |
| gie | input | 1 | Global interrupt enable |
| osc_mode | input | 2 | Oscillator mode; 2'b11 means external clock or RC |
| core_clk_en | output | 1 | Core clock enable, 0 while asleep or starting up |
| pwrdn_n | output | 1 | Power-down status, 0 after sleep was entered |
| tmo_n | output | 1 | Time-out status bit |
| wdt_clr | output | 1 | One-cycle watchdog counter, prescaler and postscaler clear |
| vec_load | output | 1 | Program-counter vector load strobe |
| vec_addr | output | 13 | Vector target address, valid with vec_load |

## Verification
Sleep requests are issued under four conditions. A wake condition may already be pending, which tells a no-operation from a real entry. A wake may arrive on the first cycle after entry or several cycles later, which shows that late interrupts still allow full completion. Every oscillator mode is paired with both global-enable values, which separates the 1024-edge and immediate release paths and the vectored and in-line resumes. Flag-without-enable patterns, and strobes sent while halted, show that inputs which must not act leave the outputs unchanged.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_START = 2'd2,
        ST_DUMMY = 2'd3
    } pwr_state_e;

    localparam logic [1:0] OSC_EXT_RC = 2'b11;

    typedef struct packed {
        pwr_state_e state;
        logic       pwrdn_n;
        logic       tmo_n;
        logic       wdt_clr;
        logic       vec_load;
    } seq_regs_t;

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic [NUM_SRC-1:0] irq_flag,
    output logic               wake
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = irq_en[i] & irq_flag[i];
    end

    assign wake = |hit;

endmodule

// File: rtl/pwr_ost_timer.sv
module pwr_ost_timer #(
    parameter int OST_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(OST_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OST_LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        ready_o = run_i && (cnt_q == LAST);
        if (!run_i || ready_o) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: the counter rests at zero between start-up windows
    a_r6_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

    // R6: the ready pulse is a single cycle
    a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_sleep_pkg::*;
#(
    parameter int          ADDR_W   = 13,
    parameter logic [12:0] VEC_ADDR = 13'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              clrwdt_req,
    input  logic              wake,
    input  logic              gie,
    input  logic              needs_ost,
    input  logic              ost_ready,
    output logic              ost_run,
    output logic              core_clk_en,
    output logic              pwrdn_n,
    output logic              tmo_n,
    output logic              wdt_clr,
    output logic              vec_load,
    output logic [ADDR_W-1:0] vec_addr
);
    seq_regs_t q, d;
    pwr_state_e resume_state;

    always_comb begin
        resume_state = gie ? ST_DUMMY : ST_RUN;
        d            = q;
        d.wdt_clr    = 1'b0;
        d.vec_load   = 1'b0;
        case (q.state)
            ST_RUN: begin
                if (clrwdt_req) begin
                    d.wdt_clr = 1'b1;
                    d.pwrdn_n = 1'b1;
                    d.tmo_n   = 1'b1;
                end
                if (sleep_req && !wake) begin
                    d.state   = ST_SLEEP;
                    d.wdt_clr = 1'b1;
                    d.pwrdn_n = 1'b0;
                    d.tmo_n   = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (wake) d.state = needs_ost ? ST_START : resume_state;
            end
            ST_START: begin
                if (ost_ready) d.state = resume_state;
            end
            default: begin
                d.state    = ST_RUN;
                d.vec_load = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= ST_RUN;
            q.pwrdn_n  <= 1'b1;
            q.tmo_n    <= 1'b1;
            q.wdt_clr  <= 1'b0;
            q.vec_load <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ost_run     = (q.state == ST_START);
    assign core_clk_en = (q.state == ST_RUN) || (q.state == ST_DUMMY);
    assign pwrdn_n     = q.pwrdn_n;
    assign tmo_n       = q.tmo_n;
    assign wdt_clr     = q.wdt_clr;
    assign vec_load    = q.vec_load;
    assign vec_addr    = q.vec_load ? VEC_ADDR[ADDR_W-1:0] : '0;

    // R3: a pending wake turns sleep into a no-operation
    a_r3_nop_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RUN && sleep_req && wake && !clrwdt_req)
        |=> (core_clk_en && !wdt_clr && $stable(pwrdn_n) && $stable(tmo_n)));

    // R4: a real entry gates the core and updates status
    a_r4_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RUN && sleep_req && !wake)
        |=> (!core_clk_en && wdt_clr && !pwrdn_n && tmo_n));

    // R5: without wake the core stays asleep
    a_r5_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SLEEP && !wake) |=> (q.state == ST_SLEEP));

    // R7: the vector load follows the dummy cycle
    a_r7_vector_after_dummy: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> ($past(q.state) == ST_DUMMY && vec_addr == VEC_ADDR[ADDR_W-1:0]));

    // R10: no watchdog clear arises from a halted core
    a_r10_halted_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SLEEP || q.state == ST_START) |=> !wdt_clr);

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int OST_LEN = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               clrwdt_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic [NUM_SRC-1:0] irq_flag,
    input  logic               gie,
    input  logic [1:0]         osc_mode,
    output logic               core_clk_en,
    output logic               pwrdn_n,
    output logic               tmo_n,
    output logic               wdt_clr,
    output logic               vec_load,
    output logic [12:0]        vec_addr
);
    logic wake, ost_run, ost_ready, needs_ost;

    assign needs_ost = (osc_mode != OSC_EXT_RC);

    pwr_wake_detect #(.NUM_SRC(NUM_SRC)) u_wake (
        .irq_en   (irq_en),
        .irq_flag (irq_flag),
        .wake     (wake)
    );

    pwr_ost_timer #(.OST_LEN(OST_LEN)) u_ost (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ost_run),
        .ready_o (ost_ready)
    );

    pwr_seq_fsm #(.ADDR_W(13), .VEC_ADDR(13'h0004)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .clrwdt_req  (clrwdt_req),
        .wake        (wake),
        .gie         (gie),
        .needs_ost   (needs_ost),
        .ost_ready   (ost_ready),
        .ost_run     (ost_run),
        .core_clk_en (core_clk_en),
        .pwrdn_n     (pwrdn_n),
        .tmo_n       (tmo_n),
        .wdt_clr     (wdt_clr),
        .vec_load    (vec_load),
        .vec_addr    (vec_addr)
    );

    // R2: a wake while running never gates the core on its own
    a_r2_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && !sleep_req) |=> core_clk_en);

endmodule

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, clrwdt_req = 1'b0, gie = 1'b0;
    logic [N-1:0] irq_en = '0, irq_flag = '0;
    logic [1:0] osc_mode = 2'b11;
    logic core_clk_en, pwrdn_n, tmo_n, wdt_clr, vec_load;
    logic [12:0] vec_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_sleep_ctrl #(.NUM_SRC(N), .OST_LEN(1024)) i_pwr_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .clrwdt_req(clrwdt_req),
        .irq_en(irq_en), .irq_flag(irq_flag), .gie(gie), .osc_mode(osc_mode),
        .core_clk_en(core_clk_en), .pwrdn_n(pwrdn_n), .tmo_n(tmo_n),
        .wdt_clr(wdt_clr), .vec_load(vec_load), .vec_addr(vec_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_wait(input logic [1:0] mode);
        return (mode == 2'b11) ? 1 : 1025;
    endfunction

    task automatic set_wake(input bit on);
        int src = $urandom % N;
        irq_flag = N'(1) << src;
        if (on) irq_en = N'($urandom) | (N'(1) << src);
        else    irq_en = N'($urandom) & ~(N'(1) << src);
    endtask

    task automatic clear_flags();
        irq_flag = '0;
        irq_en   = N'($urandom);
    endtask

    task automatic do_clrwdt();
        clrwdt_req = 1'b1;
        @(negedge clk);
        clrwdt_req = 1'b0;
        check(wdt_clr == 1'b1, "R9 wdt_clr", int'(wdt_clr), 1);
        check(pwrdn_n == 1'b1 && tmo_n == 1'b1, "R9 status", int'({pwrdn_n, tmo_n}), 3);
        @(negedge clk);
        check(wdt_clr == 1'b0, "R9 pulse width", int'(wdt_clr), 0);
    endtask

    task automatic scenario(input bit pre, input int gap, input bit g, input logic [1:0] mode,
                            input bit probe);
        int cnt;
        do_clrwdt();
        gie = g;
        osc_mode = mode;
        if (pre) set_wake(1'b1); else clear_flags();
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        if (pre) begin
            check(core_clk_en == 1'b1, "R3 keeps running", int'(core_clk_en), 1);
            check(wdt_clr == 1'b0, "R3 no wdt clear", int'(wdt_clr), 0);
            check(pwrdn_n == 1'b1 && tmo_n == 1'b1, "R3 status kept", int'({pwrdn_n, tmo_n}), 3);
            check(vec_load == 1'b0 && vec_addr == 13'h0, "R8 no vector on nop", int'(vec_load), 0);
            clear_flags();
            return;
        end
        check(core_clk_en == 1'b0, "R4 clock gated", int'(core_clk_en), 0);
        check(wdt_clr == 1'b1, "R4 wdt clear", int'(wdt_clr), 1);
        check(pwrdn_n == 1'b0 && tmo_n == 1'b1, "R4 status", int'({pwrdn_n, tmo_n}), 1);
        if (probe) begin
            set_wake(1'b0);
            sleep_req = 1'b1;
            clrwdt_req = 1'b1;
            gie = ~g;
            @(negedge clk);
            sleep_req = 1'b0;
            clrwdt_req = 1'b0;
            gie = g;
            check(core_clk_en == 1'b0, "R2 flag without enable", int'(core_clk_en), 0);
            check(wdt_clr == 1'b0, "R10 no wdt clear asleep", int'(wdt_clr), 0);
            check(pwrdn_n == 1'b0, "R10 status held asleep", int'(pwrdn_n), 0);
            clear_flags();
        end
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            check(core_clk_en == 1'b0 && wdt_clr == 1'b0, "R5 stays asleep",
                  int'({core_clk_en, wdt_clr}), 0);
        end
        gie = ~g;
        set_wake(1'b1);
        gie = g;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) clear_flags();
        end while (!core_clk_en && cnt < 3000);
        check(cnt == exp_wait(mode), "R6 start-up length", cnt, exp_wait(mode));
        check(pwrdn_n == 1'b0 && tmo_n == 1'b1, "R5 status after wake", int'({pwrdn_n, tmo_n}), 1);
        check(vec_load == 1'b0, "R7 dummy or inline cycle", int'(vec_load), 0);
        @(negedge clk);
        if (g) begin
            check(vec_load == 1'b1, "R7 vector load", int'(vec_load), 1);
            check(vec_addr == 13'h0004, "R7 vector address", int'(vec_addr), 4);
        end else begin
            check(vec_load == 1'b0 && vec_addr == 13'h0, "R8 inline resume", int'(vec_load), 0);
        end
        @(negedge clk);
        check(vec_load == 1'b0 && core_clk_en == 1'b1, "R7 single vector pulse",
              int'({vec_load, core_clk_en}), 1);
    endtask

    initial begin
        void'($urandom(32'd1377));
        repeat (3) @(negedge clk);
        check(pwrdn_n == 1'b1 && tmo_n == 1'b1, "R1 status at reset", int'({pwrdn_n, tmo_n}), 3);
        check(core_clk_en == 1'b1 && wdt_clr == 1'b0 && vec_load == 1'b0, "R1 outputs at reset",
              int'({core_clk_en, wdt_clr, vec_load}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        set_wake(1'b1);
        @(negedge clk);
        check(core_clk_en == 1'b1, "R2 wake alone does not gate", int'(core_clk_en), 1);
        clear_flags();
        // directed corners
        scenario(1'b1, 0, 1'b1, 2'b00, 1'b0);
        scenario(1'b0, 0, 1'b0, 2'b11, 1'b0);
        scenario(1'b0, 0, 1'b1, 2'b11, 1'b1);
        scenario(1'b0, 3, 1'b1, 2'b01, 1'b1);
        scenario(1'b0, 2, 1'b0, 2'b10, 1'b0);
        scenario(1'b0, 1, 1'b0, 2'b00, 1'b1);
        // random mix
        for (int k = 0; k < 24; k++) begin
            scenario(($urandom % 4) == 0, int'($urandom % 6), 1'($urandom),
                     2'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule